// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Accumulate Unit

This unit is the multiply engine of a small CPU. One start strobe launches one operation, picked by a 3-bit select. The operation can be a narrow (8×8) multiply, a wide (16×16) multiply, or a signed 16×16 product added to a 32-bit accumulator value. The multiplies come in unsigned and two's-complement forms. The caller supplies the operands and the current accumulator value, and writes the result back itself. The block only computes.

A single shift-and-add engine works on operand magnitudes for every width and signedness. A sign fix-up and an adder follow it. Each operation takes the same number of cycles. A one-cycle done pulse marks the moment the result and the N, Z, V and C flags become valid. Those outputs then stay frozen until the next done pulse.

Top module: `mac_unit`

## Requirements
- R1: Select code 0 (unsigned narrow): `res_o[15:0]` is the unsigned product of `a_i[7:0]` and `b_i[7:0]`, and `res_o[31:16]` is zero.
- R2: Select code 1 (signed narrow): `res_o[15:0]` is the two's-complement product of `a_i[7:0]` and `b_i[7:0]`, and `res_o[31:16]` is zero.
- R3: Select code 2 (unsigned wide): `res_o` is the 32-bit unsigned product of `a_i` and `b_i`.
- R4: Select code 3 (signed wide): `res_o` is the 32-bit two's-complement product of `a_i` and `b_i`.
- R5: Select codes 4 to 7 (accumulate): `res_o` is `acc_i` plus the signed wide product of `a_i` and `b_i`, wrapped modulo 2^32. `acc_i` is sampled in the cycle the start is accepted.
- R6: `v_o` is 1 only when an accumulate produces a sum outside the signed 32-bit range. For every multiply-only code, `v_o` is 0.
- R7: `n_o` is the top bit of the result field (bit 15 for codes 0 and 1, bit 31 otherwise). `z_o` is 1 exactly when that field is zero.
- R8: `c_o` equals product bit 7 for code 0 and is 0 for every other code.
- R9: `done_o` is high for exactly one cycle. That cycle begins at the 17th rising clock edge after the edge that accepts `start_i`.
- R10: A `start_i` that arrives while an operation is in flight is ignored. It produces no extra done pulse and does not change the result.
- R11: `res_o` and the flags keep their values between done pulses. After reset they are zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation (accepted only when idle) |
| op_i | input | 3 | Operation select, sampled with start |
| a_i | input | 16 | First operand (narrow codes use bits 7:0) |
| b_i | input | 16 | Second operand (narrow codes use bits 7:0) |
| acc_i | input | 32 | Accumulator value for codes 4 to 7 |
| res_o | output | 32 | Product or new accumulator value |
| n_o | output | 1 | Result negative |
| z_o | output | 1 | Result zero |
| v_o | output | 1 | Accumulate signed overflow |
| c_o | output | 1 | Bit 7 of the unsigned narrow product |
| done_o | output | 1 | Result valid pulse |

## Verification
The bench builds the unit with the default width of 16. Operand extremes are therefore cheap to reach: -32768 squared, 0xFFFF squared and -128 squared, plus accumulator values at both ends of the signed 32-bit range, which push the sum across overflow in each direction. The default width also keeps the 17-cycle latency short, so a stray start can be inserted mid-operation and a few hundred mixed operations fit well within the run time.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef struct packed {
    logic narrow;
    logic sgn;
    logic mac;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [2:0] op);
    op_dec_t d;
    d.mac    = op[2];
    d.narrow = !op[2] && !op[1];
    d.sgn    = op[2] || op[0];
    return d;
  endfunction
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl #(
  parameter int LAT = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic fin_o,
  output logic done_o
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt_q;

  assign accept_o = start_i && (cnt_q == '0);
  assign step_o   = cnt_q > CW'(1);
  assign fin_o    = cnt_q == CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= fin_o;
      if (accept_o)          cnt_q <= CW'(LAT);
      else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && start_i |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   a_mag_i,
  input  logic [W-1:0]   b_mag_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;
  logic [PW-1:0] mcand_q, prod_q;
  logic [W-1:0]  mpl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      mpl_q   <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= {{W{1'b0}}, a_mag_i};
      mpl_q   <= b_mag_i;
      prod_q  <= '0;
    end else if (step_i) begin
      if (mpl_q[0]) prod_q <= prod_q + mcand_q;
      mcand_q <= mcand_q << 1;
      mpl_q   <= mpl_q >> 1;
    end
  end

  assign prod_o = prod_q;

  // R3
  skip_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !mpl_q[0] |=> $stable(prod_q));
endmodule

// File: rtl/mac_post.sv
module mac_post #(
  parameter int W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fin_i,
  input  mac_pkg::op_dec_t dec_i,
  input  logic             neg_i,
  input  logic [2*W-1:0]   prod_i,
  input  logic [2*W-1:0]   acc_i,
  output logic [2*W-1:0]   res_o,
  output logic             n_o,
  output logic             z_o,
  output logic             v_o,
  output logic             c_o
);
  localparam int PW = 2 * W;
  localparam int NW = W / 2;

  logic [PW-1:0] sp, sum, res_d;
  logic          v_d, n_d, c_d;

  always_comb begin
    sp  = neg_i ? (~prod_i + PW'(1)) : prod_i;
    sum = acc_i + sp;
    v_d = 1'b0;
    if (dec_i.mac) begin
      res_d = sum;
      v_d   = (acc_i[PW-1] == sp[PW-1]) && (sum[PW-1] != acc_i[PW-1]);
    end else if (dec_i.narrow) begin
      res_d = {{W{1'b0}}, sp[W-1:0]};
    end else begin
      res_d = sp;
    end
    n_d = dec_i.narrow ? res_d[W-1] : res_d[PW-1];
    c_d = dec_i.narrow && !dec_i.sgn && sp[NW-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      n_o   <= 1'b0;
      z_o   <= 1'b0;
      v_o   <= 1'b0;
      c_o   <= 1'b0;
    end else if (fin_i) begin
      res_o <= res_d;
      n_o   <= n_d;
      z_o   <= res_d == '0;
      v_o   <= v_d;
      c_o   <= c_d;
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i && !dec_i.mac |=> !v_o);
  // R11
  hold_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> $stable(res_o));
  // R1
  narrow_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i && dec_i.narrow && !dec_i.mac |=> res_o[PW-1:W] == '0);
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2:0]     op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [2*W-1:0] acc_i,
  output logic [2*W-1:0] res_o,
  output logic           n_o,
  output logic           z_o,
  output logic           v_o,
  output logic           c_o,
  output logic           done_o
);
  import mac_pkg::*;
  localparam int PW  = 2 * W;
  localparam int NW  = W / 2;
  localparam int LAT = W + 1;

  logic accept, step, fin;
  op_dec_t dec_in, dec_q;
  logic neg_q;
  logic [PW-1:0] acc_q, prod;
  logic [W-1:0] opnd [2];
  logic [W-1:0] ext  [2];
  logic [W-1:0] mag  [2];
  logic [1:0]   sbit;

  assign dec_in  = decode_op(op_i);
  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    always_comb begin
      if (dec_in.narrow)
        ext[g] = dec_in.sgn ? {{(W-NW){opnd[g][NW-1]}}, opnd[g][NW-1:0]}
                            : {{(W-NW){1'b0}}, opnd[g][NW-1:0]};
      else
        ext[g] = opnd[g];
      sbit[g] = dec_in.sgn && ext[g][W-1];
      mag[g]  = sbit[g] ? (~ext[g] + W'(1)) : ext[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= '0;
      neg_q <= 1'b0;
      acc_q <= '0;
    end else if (accept) begin
      dec_q <= dec_in;
      neg_q <= sbit[0] ^ sbit[1];
      acc_q <= acc_i;
    end
  end

  mac_ctrl #(.LAT(LAT)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .accept_o(accept), .step_o(step), .fin_o(fin), .done_o(done_o)
  );

  mac_mul #(.W(W)) u_mul (
    .clk_i, .rst_ni, .load_i(accept), .step_i(step),
    .a_mag_i(mag[0]), .b_mag_i(mag[1]), .prod_o(prod)
  );

  mac_post #(.W(W)) u_post (
    .clk_i, .rst_ni, .fin_i(fin), .dec_i(dec_q), .neg_i(neg_q),
    .prod_i(prod), .acc_i(acc_q),
    .res_o, .n_o, .z_o, .v_o, .c_o
  );

  // R8
  carry_only_unsigned_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !(dec_q.narrow && !dec_q.sgn) |-> !c_o);
endmodule

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY = W + 2;

  typedef struct {
    logic [31:0] res;
    logic n, z, v, c;
    int  start_cyc;
    int  op;
  } exp_t;

  logic clk = 0, rst_ni = 0, start_i = 0;
  logic [2:0] op_i = 0;
  logic [15:0] a_i = 0, b_i = 0;
  logic [31:0] acc_i = 0, res_o;
  logic n_o, z_o, v_o, c_o, done_o;

  int checks = 0, errors = 0, cyc = 0;
  exp_t q[$];
  logic have_last = 0, prev_done = 0;
  logic [31:0] last_res;

  mac_unit #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni, .start_i, .op_i, .a_i, .b_i, .acc_i,
    .res_o, .n_o, .z_o, .v_o, .c_o, .done_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input int op, input logic [15:0] a, input logic [15:0] b, input logic [31:0] acc);
    exp_t e;
    longint p, s;
    logic [15:0] lo;
    e.v = 0; e.c = 0; e.op = op; e.start_cyc = 0;
    if (op >= 4) begin
      p = longint'($signed(a)) * longint'($signed(b));
      s = longint'($signed(acc)) + p;
      e.res = s[31:0];
      e.v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      e.n = e.res[31]; e.z = (e.res == 0);
    end else if (op >= 2) begin
      if (op == 3) p = longint'($signed(a)) * longint'($signed(b));
      else         p = longint'(a) * longint'(b);
      e.res = p[31:0];
      e.n = e.res[31]; e.z = (e.res == 0);
    end else begin
      if (op == 1) p = longint'($signed(a[7:0])) * longint'($signed(b[7:0]));
      else         p = longint'(a[7:0]) * longint'(b[7:0]);
      lo = p[15:0];
      e.res = {16'h0, lo};
      e.n = lo[15]; e.z = (lo == 0);
      e.c = (op == 0) && lo[7];
    end
    return e;
  endfunction

  task automatic issue(input int op, input logic [15:0] a, input logic [15:0] b, input logic [31:0] acc);
    exp_t e;
    @(negedge clk);
    e = model(op, a, b, acc);
    e.start_cyc = cyc;
    q.push_back(e);
    op_i = 3'(op); a_i = a; b_i = b; acc_i = acc; start_i = 1;
    @(negedge clk);
    start_i = 0;
    a_i = ~a; b_i = ~b; acc_i = ~acc;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done_o) begin
        check(!prev_done, "R9 done longer than one cycle", 32'(done_o), 32'(0));
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected done", 32'(done_o), 32'(0));
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc - e.start_cyc == LATENCY, "R9 latency", 32'(cyc - e.start_cyc), 32'(LATENCY));
          case (e.op)
            0: check(res_o == e.res, "R1 result", res_o, e.res);
            1: check(res_o == e.res, "R2 result", res_o, e.res);
            2: check(res_o == e.res, "R3 result", res_o, e.res);
            3: check(res_o == e.res, "R4 result", res_o, e.res);
            default: check(res_o == e.res, "R5 result", res_o, e.res);
          endcase
          check(v_o == e.v, "R6 overflow flag", 32'(v_o), 32'(e.v));
          check({n_o, z_o} == {e.n, e.z}, "R7 N/Z flags", 32'({n_o, z_o}), 32'({e.n, e.z}));
          check(c_o == e.c, "R8 carry flag", 32'(c_o), 32'(e.c));
          last_res = res_o;
          have_last = 1;
        end
      end else if (have_last) begin
        check(res_o == last_res, "R11 hold", res_o, last_res);
      end
      prev_done = done_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'(cyc), 32'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R11 reset state
    check(res_o == 0, "R11 reset res", res_o, 0);
    check({n_o, z_o, v_o, c_o, done_o} == 0, "R11 reset flags", 32'({n_o, z_o, v_o, c_o, done_o}), 0);

    issue(0, 16'h00FF, 16'h00FF, 0); wait_idle();       // R1 max unsigned narrow
    issue(0, 16'hAB0C, 16'h5509, 0); wait_idle();       // R1 upper bytes ignored, R8 c
    issue(0, 16'h0000, 16'h0077, 0); wait_idle();       // R7 zero
    issue(1, 16'h0080, 16'h0080, 0); wait_idle();       // R2 -128*-128
    issue(1, 16'h007F, 16'h0080, 0); wait_idle();       // R2 negative
    issue(2, 16'hFFFF, 16'hFFFF, 0); wait_idle();       // R3
    issue(3, 16'h8000, 16'h8000, 0); wait_idle();       // R4 -32768^2
    issue(3, 16'h8000, 16'h7FFF, 0); wait_idle();       // R4 negative
    issue(4, 16'h7FFF, 16'h7FFF, 32'h7FFF_0000); wait_idle(); // R6 positive overflow
    issue(4, 16'h8000, 16'h7FFF, 32'h8000_0000); wait_idle(); // R6 negative overflow
    issue(5, 16'hFFFF, 16'h0001, 32'h0000_0001); wait_idle(); // R5 zero sum
    issue(7, 16'h0003, 16'hFFFE, 32'h0000_0010); wait_idle(); // R5 code 7

    // R10: stray start mid-operation
    issue(2, 16'h1234, 16'h5678, 0);
    repeat (5) @(negedge clk);
    op_i = 3'd3; a_i = 16'hFFFF; b_i = 16'h0002; start_i = 1;
    @(negedge clk);
    start_i = 0;
    wait_idle();
    repeat (30) @(negedge clk);

    for (int i = 0; i < 300; i++) begin
      issue(int'($urandom_range(0, 7)), 16'($urandom), 16'($urandom), $urandom);
      wait_idle();
    end

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule